// File: doc/BRIEF.md
# Twisted-Pair Transmit Framing Sequencer

This block turns a stream of NRZ transmit bits, qualified by a transmit-enable flag, into the digital bit pattern that drives a 10BASE-T twisted-pair line. It runs on a clock at twice the bit rate, so each bit cell takes two clock cycles. Each data bit is Manchester coded. When transmit-enable drops, an end-of-packet marker follows: the line is held high for a fixed number of bit times and then returns low. While the line is idle it stays low, and a short link test pulse is inserted at a regular interval. A free-running prescaler and interval counter time these pulses.

While a packet is being sent, the coded stream is also copied to a loopback output for the receive path. A collision or link-fail indication silences that copy. A link pulse that falls due while a packet or end marker is on the line is held back and sent once the line is idle again. Pulse shaping and the analog driver sit outside this block.

Top module: `tx_frame_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `line_out`, `line_active` and `loop_out` are all 0.
- R2: A data bit occupies two cycles. The first half drives the inverse of the bit and the second half drives the bit itself, so a 1 is sent as low-then-high and a 0 as high-then-low.
- R3: When `tx_en` is 1 at a rising edge while the line is idle, a packet starts. The `tx_data` sampled at that edge becomes the first bit cell, beginning on the next cycle. During a packet, `tx_en` and `tx_data` are sampled again at the edge that ends each cell's second half.
- R4: When `tx_en` is 0 at the end of a cell, the line is driven high for `SOI_BITS*2` cycles (default 3 bit times) and then goes idle. `tx_en` is ignored during this marker.
- R5: While idle, `line_out` is 0 except during a link pulse.
- R6: The link timer expires every `TICK_DIV*LINK_TICKS` cycles, counted from reset. An expiry seen while idle is followed, one cycle later, by a link pulse that holds `line_out` high for `LINK_HALVES` cycles.
- R7: An expiry that occurs while a packet, end marker or pulse is on the line is remembered. Exactly one link pulse is sent at the first idle cycle afterwards, and several expiries merge into one pending pulse.
- R8: During packet data, when neither `coll_i` nor `link_fail_i` is 1, `loop_out` equals `line_out`.
- R9: `loop_out` is 0 whenever `coll_i` or `link_fail_i` is 1, and whenever no packet data is being sent (end marker, link pulse and idle included).
- R10: At an idle edge where both `tx_en` and a pending link pulse are present, the packet starts and the pulse stays pending.
- R11: `line_active` is 1 exactly while packet data, an end marker or a link pulse is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (twice the bit rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable, NRZ framing flag |
| tx_data | input | 1 | NRZ transmit bit |
| coll_i | input | 1 | Collision present |
| link_fail_i | input | 1 | Link pulse fail condition present |
| line_out | output | 1 | Coded line bit toward the driver |
| line_active | output | 1 | Line carries data, end marker or link pulse |
| loop_out | output | 1 | Coded stream looped back to receive side |

## Verification
The bench builds the block with `TICK_DIV=4` and `LINK_TICKS=5`, so a link pulse falls due every 20 cycles instead of every 16 ms. With that short interval, many expiries occur inside random packets, which exercises deferral, merged expiries and the collision between a starting packet and a pending pulse within a few thousand cycles. The end-marker and pulse lengths keep their default values, so the measured high widths are the real ones.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SOI  = 2'd2,
    ST_LINK = 2'd3
  } txfs_state_e;

  // Manchester half-cell value: first half carries the inverse, second the bit
  function automatic logic manch_half(input logic bit_v, input logic second_half);
    return second_half ? bit_v : ~bit_v;
  endfunction

  // Loopback is allowed only for packet data with no fault condition
  function automatic logic loop_allowed(input txfs_state_e st, input logic coll,
                                        input logic lfail);
    return (st == ST_DATA) && !coll && !lfail;
  endfunction

  // Cycles of a link interval
  function automatic int unsigned link_period(input int unsigned div,
                                              input int unsigned ticks);
    return div * ticks;
  endfunction

endpackage

// File: rtl/txfs_link_timer.sv
module txfs_link_timer #(
  parameter int unsigned TICK_DIV   = 20000,
  parameter int unsigned LINK_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic pending,
  output logic expire
);
  localparam int unsigned PW = (TICK_DIV   > 1) ? $clog2(TICK_DIV)   : 1;
  localparam int unsigned TW = (LINK_TICKS > 1) ? $clog2(LINK_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(TICK_DIV - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(LINK_TICKS - 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q;
  logic          tick_ev;

  assign tick_ev = (pre_q == PRE_LAST);
  assign expire  = tick_ev && (tick_q == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (tick_ev) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (tick_ev) begin
      if (tick_q == TICK_LAST) tick_q <= '0;
      else                     tick_q <= tick_q + 1'b1;
    end
  end

  // expiry wins over a same-cycle take, so no interval is lost
  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (take)   pending <= 1'b0;
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> pending); // R7
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending); // R6

endmodule

// File: rtl/txfs_seq.sv
module txfs_seq
  import txfs_pkg::*;
#(
  parameter int unsigned SOI_BITS    = 3,
  parameter int unsigned LINK_HALVES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        tx_data,
  input  logic        pend,
  output txfs_state_e st,
  output logic        ph,
  output logic        cur_bit,
  output logic        link_take,
  output logic        cell_end,
  output logic        pkt_start
);
  localparam int unsigned SOI_HALVES = SOI_BITS * 2;
  localparam int unsigned CMAX = (SOI_HALVES > LINK_HALVES) ? SOI_HALVES : LINK_HALVES;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SOI_LOAD  = CW'(SOI_HALVES - 1);
  localparam logic [CW-1:0] LINK_LOAD = CW'(LINK_HALVES - 1);

  txfs_state_e   st_q, st_d;
  logic          ph_d, bit_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign st        = st_q;
  assign cnt_zero  = (cnt_q == '0);
  assign cell_end  = (st_q == ST_DATA) && ph;
  assign pkt_start = (st_q == ST_IDLE) && tx_en;
  assign link_take = (st_q == ST_IDLE) && !tx_en && pend;

  always_comb begin
    st_d  = st_q;
    ph_d  = ph;
    bit_d = cur_bit;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pkt_start) begin
          st_d  = ST_DATA;
          bit_d = tx_data;
          ph_d  = 1'b0;
        end else if (link_take) begin
          st_d  = ST_LINK;
          cnt_d = LINK_LOAD;
        end
      end
      ST_DATA: begin
        if (!ph) begin
          ph_d = 1'b1;
        end else if (tx_en) begin
          ph_d  = 1'b0;
          bit_d = tx_data;
        end else begin
          st_d  = ST_SOI;
          ph_d  = 1'b0;
          cnt_d = SOI_LOAD;
        end
      end
      ST_SOI, ST_LINK: begin
        if (cnt_zero) st_d = ST_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph      <= 1'b0;
      cur_bit <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      ph      <= ph_d;
      cur_bit <= bit_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_TX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && tx_en) |=> (st_q == ST_DATA)); // R10
  AST_SOI_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SOI && $past(st_q) != ST_SOI) |-> ($past(st_q) == ST_DATA)); // R4
  AST_LINK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LINK && $past(st_q) != ST_LINK) |-> ($past(st_q) == ST_IDLE)); // R7

endmodule

// File: rtl/txfs_line_out.sv
module txfs_line_out
  import txfs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  txfs_state_e st,
  input  logic        ph,
  input  logic        cur_bit,
  input  logic        coll_i,
  input  logic        link_fail_i,
  output logic        line_out,
  output logic        line_active,
  output logic        loop_out
);
  logic data_v;

  always_comb begin
    unique case (st)
      ST_DATA:          data_v = manch_half(cur_bit, ph);
      ST_SOI, ST_LINK:  data_v = 1'b1;
      default:          data_v = 1'b0;
    endcase
  end

  assign line_out    = data_v;
  assign line_active = (st != ST_IDLE);
  assign loop_out    = loop_allowed(st, coll_i, link_fail_i) ? data_v : 1'b0;

  AST_MID_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !ph) |=> (line_out != $past(line_out))); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !line_active |-> !line_out); // R5
  AST_LOOP_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_i || link_fail_i) |-> !loop_out); // R9

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import txfs_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 20000,
  parameter int unsigned LINK_TICKS  = 16,
  parameter int unsigned SOI_BITS    = 3,
  parameter int unsigned LINK_HALVES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_data,
  input  logic coll_i,
  input  logic link_fail_i,
  output logic line_out,
  output logic line_active,
  output logic loop_out
);
  txfs_state_e st;
  logic ph, cur_bit, link_take, cell_end, pkt_start, pend, expire;

  txfs_link_timer #(.TICK_DIV(TICK_DIV), .LINK_TICKS(LINK_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .take(link_take), .pending(pend), .expire(expire)
  );

  txfs_seq #(.SOI_BITS(SOI_BITS), .LINK_HALVES(LINK_HALVES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data), .pend(pend),
    .st(st), .ph(ph), .cur_bit(cur_bit), .link_take(link_take),
    .cell_end(cell_end), .pkt_start(pkt_start)
  );

  txfs_line_out u_line (
    .clk(clk), .rst_n(rst_n), .st(st), .ph(ph), .cur_bit(cur_bit),
    .coll_i(coll_i), .link_fail_i(link_fail_i),
    .line_out(line_out), .line_active(line_active), .loop_out(loop_out)
  );

  AST_START_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (line_active && line_out == !$past(tx_data))); // R3
  AST_CELL_END_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_end && tx_en) |=> (line_out == !$past(tx_data))); // R3
  AST_ACTIVE_ON_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !line_active && !tx_en) |=> (!line_active || line_out)); // R6

endmodule

// File: tb/tx_frame_seq_tb.sv
module tx_frame_seq_tb;
  localparam int TDIV = 4;
  localparam int LTK  = 5;
  localparam int PER  = TDIV * LTK;
  localparam int SOIH = 6;
  localparam int LNKH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, tx_data = 1'b0, coll_i = 1'b0, link_fail_i = 1'b0;
  logic line_out, line_active, loop_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tx_frame_seq #(.TICK_DIV(TDIV), .LINK_TICKS(LTK)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
    .coll_i(coll_i), .link_fail_i(link_fail_i),
    .line_out(line_out), .line_active(line_active), .loop_out(loop_out)
  );

  // reference model: 0 idle, 1 data, 2 end marker, 3 link pulse
  int m_mode = 0, m_half = 0, m_left = 0, m_cyc = 0;
  bit m_bit = 0, m_owed = 0;
  bit pkt [0:63];
  int pkt_len = 0, pkt_idx = 0;

  function automatic bit f_line(int mode, int half, bit b);
    if (mode == 1) return (half == 0) ? !b : b;
    return (mode == 2 || mode == 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_half = 0; m_left = 0; m_cyc = 0; m_owed = 0;
    end else begin
      bit due;
      due = ((m_cyc % PER) == PER - 1);
      m_cyc++;
      case (m_mode)
        0: if (tx_en) begin
             m_mode = 1; m_half = 0; m_bit = tx_data; pkt_idx++;
           end else if (m_owed) begin
             m_mode = 3; m_left = LNKH; m_owed = 0;
           end
        1: if (m_half == 0) m_half = 1;
           else if (tx_en) begin m_half = 0; m_bit = tx_data; pkt_idx++; end
           else begin m_mode = 2; m_left = SOIH; end
        default: begin m_left--; if (m_left == 0) m_mode = 0; end
      endcase
      if (due) m_owed = 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    bit el, ea, elp;
    el  = f_line(m_mode, m_half, m_bit);
    ea  = (m_mode != 0);
    elp = (m_mode == 1) && !coll_i && !link_fail_i && el;
    case (m_mode)
      1: chk(line_out == el, "R2/R3 data coding", line_out, el);
      2: chk(line_out == el, "R4 end marker", line_out, el);
      3: chk(line_out == el, "R6/R7 link pulse", line_out, el);
      default: chk(line_out == el, "R5 idle low", line_out, el);
    endcase
    chk(line_active == ea, "R11 active flag", line_active, ea);
    if (m_mode == 1 && !coll_i && !link_fail_i)
      chk(loop_out == elp, "R8 loopback copy", loop_out, elp);
    else
      chk(loop_out == elp, "R9 loopback muted", loop_out, elp);
  endtask

  // one cycle: check at negedge, then set inputs for the next edge
  task automatic step(bit fault_rand);
    @(negedge clk);
    compare_now();
    tx_en   = (pkt_idx < pkt_len);
    tx_data = tx_en ? pkt[pkt_idx] : 1'($urandom);
    if (fault_rand) begin
      coll_i      = ($urandom % 8) == 0;
      link_fail_i = ($urandom % 8) == 0;
    end
  endtask

  task automatic load_pkt(int len);
    for (int i = 0; i < len; i++) pkt[i] = 1'($urandom);
    pkt_len = len; pkt_idx = 0;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int highs, last_rise, gap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(line_out == 0 && line_active == 0 && loop_out == 0, "R1 reset outputs",
        {line_out, line_active, loop_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_out == 0 && line_active == 0 && loop_out == 0, "R1 after reset",
        {line_out, line_active, loop_out}, 0);

    // R6: pure idle, measure pulse spacing and width
    last_rise = -1; highs = 0;
    for (int c = 0; c < 3 * PER; c++) begin
      bit prev;
      prev = line_out;
      step(0);
      if (line_out) highs++;
      if (line_out && !prev) begin
        if (last_rise >= 0) begin
          gap = c - last_rise;
          chk(gap == PER, "R6 pulse spacing", gap, PER);
        end
        last_rise = c;
      end
    end
    chk(highs >= 2 * LNKH, "R6 pulse width total", highs, 2 * LNKH);

    // R2/R4: directed 1-0 packet, count end marker width
    load_pkt(2); pkt[0] = 1; pkt[1] = 0;
    begin
      int seen_soi;
      seen_soi = 0;
      for (int c = 0; c < 40; c++) begin
        step(0);
        if (m_mode == 2) seen_soi++;
      end
      chk(seen_soi == SOIH, "R4 end marker length", seen_soi, SOIH);
    end

    // R7: long packet crosses several expiries, then one deferred pulse
    load_pkt(3 * PER / 2 + 5);
    for (int c = 0; c < 8 * PER; c++) step(0);

    // R10: start a packet right when a pulse is owed
    while (!(m_mode == 0 && m_owed == 0 && (m_cyc % PER) == PER - 2)) step(0);
    load_pkt(4);
    for (int c = 0; c < 60; c++) step(0);

    // R8/R9: random packets with random faults and gaps
    for (int p = 0; p < 60; p++) begin
      load_pkt(1 + ($urandom % 40));
      for (int c = 0; c < 2 * pkt_len + 10 + ($urandom % 30); c++) step(1);
    end
    coll_i = 0; link_fail_i = 0;
    for (int c = 0; c < 50; c++) step(0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule